// File: doc/BRIEF.md
# Instruction Decode and Phase Sequencer

This block is the front end of a small hardwired accumulator machine. It holds the current 16-bit instruction word and splits it into an addressing-mode flag, a 3-bit operation code and a 12-bit operand address. The operation code is decoded into eight one-hot operation lines. A separate 4-bit step counter is decoded into sixteen one-hot phase lines. The control logic around the block combines these phase and operation lines to form its control terms.

The step counter advances when the surrounding control asks for the next phase and returns to phase zero on request. The block also contains one built-in control term: while operation line 3 and phase line 4 are both high, the counter is forced back to zero at the next clock edge. The datapath, memory and the remaining control equations sit outside the block.

Top module: `hwctl_front`

## Requirements
- R1: While `rst_n` is low at a clock edge, the instruction word, mode flag and step counter clear, so after that edge `op_lines` = 8'h01, `phase` = 16'h0001, `ind_flag` = 0 and `addr_field` = 0. A load request during reset has no effect.
- R2: At a clock edge with `insn_load` high, the word on `insn_data` is captured. From that edge on, `addr_field` equals bits 11..0, `ind_flag` equals bit 15 (0 = direct, 1 = indirect) and the operation code is bits 14..12.
- R3: At a clock edge with `insn_load` low, `addr_field`, `ind_flag` and `op_lines` keep their values.
- R4: `op_lines` always has exactly one bit set, and that bit's index equals the stored operation code.
- R5: `phase` always has exactly one bit set, and that bit's index equals the step counter value.
- R6: At an edge with `seq_inc` high, `seq_clr` low and the built-in term inactive, the counter advances by one.
- R7: Advancing from count 15 gives count 0.
- R8: At an edge with `seq_clr` high, the counter becomes 0.
- R9: When `seq_clr` and `seq_inc` are both high, the clear wins and the counter becomes 0.
- R10: At an edge where `op_lines[3]` and `phase[4]` are both high, the counter becomes 0, whatever `seq_inc` is. The same phase under any other operation code does not clear.
- R11: At an edge with `seq_inc`, `seq_clr` and the built-in term all inactive, the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_load | input | 1 | Capture `insn_data` at this edge |
| insn_data | input | 16 | Instruction word to capture |
| seq_inc | input | 1 | Advance the step counter |
| seq_clr | input | 1 | Return the step counter to zero |
| op_lines | output | 8 | One-hot decoded operation code |
| phase | output | 16 | One-hot decoded step counter |
| ind_flag | output | 1 | Stored addressing-mode bit (1 = indirect) |
| addr_field | output | 12 | Stored operand address |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. A captured word shows on `addr_field`, `ind_flag` and `op_lines` after the loading edge, and a counter action shows on `phase` after the edge where it was requested. The decoders are combinational behind these registers, so they add no cycle. The bench applies each stimulus at a falling edge and queues the expected outputs for the edge that follows. The monitor samples a quarter period after that rising edge and compares one queued item per cycle, so every expected value is checked in the cycle where it first becomes due.

// File: rtl/hwctl_pkg.sv
// Package: hwctl_pkg
// Shared default widths and the step-counter action encoding used by the
// instruction decode and phase sequencer. Assumes nothing beyond 1800-2017.
package hwctl_pkg;

    localparam int DEF_INSN_W = 16;
    localparam int DEF_ADDR_W = 12;
    localparam int DEF_OP_W   = 3;
    localparam int DEF_SEQ_W  = 4;

    // What the step counter does at the next edge.
    typedef enum logic [1:0] {
        SEQ_HOLD = 2'b00,
        SEQ_STEP = 2'b01,
        SEQ_ZERO = 2'b10
    } seq_act_e;

endpackage

// File: rtl/insn_capture.sv
// Module: insn_capture
// Holds the instruction word and splits it into the address field, the
// operation code and the addressing-mode bit. The mode bit has a flop of its
// own. Assumes INSN_W = ADDR_W + OP_W + 1, with the mode bit on top.
module insn_capture #(
    parameter int INSN_W = 16,
    parameter int ADDR_W = 12,
    parameter int OP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [INSN_W-1:0] din,
    output logic [ADDR_W-1:0] addr,
    output logic [OP_W-1:0]   opcode,
    output logic              mode
);
    localparam int OP_LSB   = ADDR_W;
    localparam int OP_MSB   = ADDR_W + OP_W - 1;
    localparam int MODE_BIT = INSN_W - 1;
    localparam int BODY_W   = INSN_W - 1;

    logic [BODY_W-1:0] body_q;
    logic              mode_q;

    // Capture the word below the mode bit on a load strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            body_q <= '0;
        end else if (load) begin
            body_q <= din[BODY_W-1:0];
        end
    end

    // Addressing-mode flop, loaded together with the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (load) begin
            mode_q <= din[MODE_BIT];
        end
    end

    // Split the stored word into its fields.
    always_comb begin
        addr   = body_q[ADDR_W-1:0];
        opcode = body_q[OP_MSB:OP_LSB];
        mode   = mode_q;
    end

endmodule

// File: rtl/onehot_dec.sv
// Module: onehot_dec
// Binary to one-hot decoder with 2**SEL_W outputs. Exactly one output is high
// for every select value. Purely combinational.
module onehot_dec #(
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0]      sel,
    output logic [(1<<SEL_W)-1:0] lines
);
    localparam int N_OUT = 1 << SEL_W;

    // One compare per output line.
    for (genvar k = 0; k < N_OUT; k++) begin : g_line
        assign lines[k] = (sel == SEL_W'(k));
    end

endmodule

// File: rtl/seq_counter.sv
// Module: seq_counter
// Binary step counter that steps, returns to zero or holds, as the action
// input says. It wraps from its maximum value to zero. The caller resolves
// priority before the action reaches this module.
module seq_counter
    import hwctl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_act_e         act,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count from the requested action; the step wraps naturally.
    always_comb begin
        unique case (act)
            SEQ_STEP: cnt_d = cnt_q + CNT_W'(1);
            SEQ_ZERO: cnt_d = '0;
            default:  cnt_d = cnt_q;
        endcase
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/hwctl_front.sv
// Module: hwctl_front
// Instruction decode and phase sequencer. It stores the instruction word,
// decodes the operation code and the step counter into one-hot lines, and
// returns the counter to zero on an external clear or when operation line
// CLR_OP meets phase line CLR_PHASE. Either clear wins over an increment.
// Assumes a single clock and a synchronous active-low reset.
module hwctl_front
    import hwctl_pkg::*;
#(
    parameter int INSN_W    = DEF_INSN_W,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int OP_W      = DEF_OP_W,
    parameter int SEQ_W     = DEF_SEQ_W,
    parameter int CLR_OP    = 3,
    parameter int CLR_PHASE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     insn_load,
    input  logic [INSN_W-1:0]        insn_data,
    input  logic                     seq_inc,
    input  logic                     seq_clr,
    output logic [(1<<OP_W)-1:0]     op_lines,
    output logic [(1<<SEQ_W)-1:0]    phase,
    output logic                     ind_flag,
    output logic [ADDR_W-1:0]        addr_field
);
    localparam int N_OPS    = 1 << OP_W;
    localparam int N_PHASES = 1 << SEQ_W;

    logic [OP_W-1:0]  opcode;
    logic [SEQ_W-1:0] step;
    logic             term_clr;
    seq_act_e         act;

    insn_capture #(
        .INSN_W (INSN_W),
        .ADDR_W (ADDR_W),
        .OP_W   (OP_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (insn_load),
        .din    (insn_data),
        .addr   (addr_field),
        .opcode (opcode),
        .mode   (ind_flag)
    );

    onehot_dec #(.SEL_W(OP_W)) u_op_dec (
        .sel   (opcode),
        .lines (op_lines)
    );

    onehot_dec #(.SEL_W(SEQ_W)) u_ph_dec (
        .sel   (step),
        .lines (phase)
    );

    // Built-in control term: the chosen operation meets the chosen phase.
    always_comb begin
        term_clr = op_lines[CLR_OP] & phase[CLR_PHASE];
    end

    // Resolve counter priority: a clear of either kind, then a step, then hold.
    always_comb begin
        if (seq_clr || term_clr) begin
            act = SEQ_ZERO;
        end else if (seq_inc) begin
            act = SEQ_STEP;
        end else begin
            act = SEQ_HOLD;
        end
    end

    seq_counter #(.CNT_W(SEQ_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .count (step)
    );

    // Elaboration guard on the field layout and term indices.
    initial begin
        if (INSN_W != ADDR_W + OP_W + 1 || CLR_OP >= N_OPS || CLR_PHASE >= N_PHASES)
            $error("hwctl_front: bad parameter set");
    end

endmodule

// File: rtl/hwctl_front_chk.sv
// Module: hwctl_front_chk
// Property checker for hwctl_front, attached through bind. It looks only at
// the ports of the top module.
module hwctl_front_chk #(
    parameter int ADDR_W    = 12,
    parameter int INSN_W    = 16,
    parameter int N_OPS     = 8,
    parameter int N_PHASES  = 16,
    parameter int CLR_OP    = 3,
    parameter int CLR_PHASE = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                insn_load,
    input logic [INSN_W-1:0]   insn_data,
    input logic                seq_inc,
    input logic                seq_clr,
    input logic [N_OPS-1:0]    op_lines,
    input logic [N_PHASES-1:0] phase,
    input logic                ind_flag,
    input logic [ADDR_W-1:0]   addr_field
);
    logic term_seen;
    assign term_seen = op_lines[CLR_OP] && phase[CLR_PHASE];

    // R4
    op_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(op_lines) == 1);

    // R5
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);

    // R2
    load_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_load |=> (addr_field == $past(insn_data[ADDR_W-1:0]))
                   && (ind_flag == $past(insn_data[INSN_W-1])));

    // R3
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_load |=> $stable(addr_field) && $stable(ind_flag) && $stable(op_lines));

    // R6
    step_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_inc && !seq_clr && !term_seen)
            |=> phase == {$past(phase[N_PHASES-2:0]), $past(phase[N_PHASES-1])});

    // R8
    ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clr |=> phase[0]);

    // R10
    term_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_seen |=> phase[0]);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_inc && !seq_clr && !term_seen) |=> $stable(phase));

endmodule

bind hwctl_front hwctl_front_chk #(
    .ADDR_W    (ADDR_W),
    .INSN_W    (INSN_W),
    .N_OPS     (1 << OP_W),
    .N_PHASES  (1 << SEQ_W),
    .CLR_OP    (CLR_OP),
    .CLR_PHASE (CLR_PHASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_load  (insn_load),
    .insn_data  (insn_data),
    .seq_inc    (seq_inc),
    .seq_clr    (seq_clr),
    .op_lines   (op_lines),
    .phase      (phase),
    .ind_flag   (ind_flag),
    .addr_field (addr_field)
);

// File: tb/sim_hwctl_front.sv
module sim_hwctl_front;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_load = 1'b0;
    logic [15:0] insn_data = '0;
    logic        seq_inc = 1'b0;
    logic        seq_clr = 1'b0;
    logic [7:0]  op_lines;
    logic [15:0] phase;
    logic        ind_flag;
    logic [11:0] addr_field;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwctl_front u0 (
        .clk(clk), .rst_n(rst_n), .insn_load(insn_load), .insn_data(insn_data),
        .seq_inc(seq_inc), .seq_clr(seq_clr), .op_lines(op_lines), .phase(phase),
        .ind_flag(ind_flag), .addr_field(addr_field)
    );

    typedef struct {
        logic [7:0]  op;
        logic [15:0] ph;
        logic        ind;
        logic [11:0] addr;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   mon_on = 0;
    bit   summary_done = 0;

    // Reference state built from the requirements.
    logic [2:0]  m_op = '0;
    logic [3:0]  m_cnt = '0;
    logic        m_ind = 1'b0;
    logic [11:0] m_addr = '0;

    task automatic compare(input exp_t e);
        n_chk++;
        if (op_lines !== e.op || phase !== e.ph || ind_flag !== e.ind || addr_field !== e.addr) begin
            n_bad++;
            $display("FAIL %s: got op=%h ph=%h ind=%b addr=%h exp op=%h ph=%h ind=%b addr=%h",
                     e.tag, op_lines, phase, ind_flag, addr_field, e.op, e.ph, e.ind, e.addr);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue what the next edge gives.
    task automatic drive(input logic ld, input logic [15:0] d, input logic inc,
                         input logic clr, input string tag);
        exp_t e;
        logic term;
        @(negedge clk);
        insn_load = ld; insn_data = d; seq_inc = inc; seq_clr = clr;
        term = (m_op == 3'd3) && (m_cnt == 4'd4);
        if (clr || term) m_cnt = 4'd0;
        else if (inc)    m_cnt = m_cnt + 4'd1;
        if (ld) begin
            m_ind = d[15]; m_op = d[14:12]; m_addr = d[11:0];
        end
        e.op = 8'h01 << m_op; e.ph = 16'h0001 << m_cnt;
        e.ind = m_ind; e.addr = m_addr; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: one comparison per cycle, a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (mon_on && sb.size() > 0) compare(sb.pop_front());
        end
    end

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung run exp completion");
        finish_run();
    end

    initial begin
        exp_t r;
        // R1: reset dominates a load request
        insn_load = 1'b1; insn_data = 16'hFFFF; seq_inc = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        r.op = 8'h01; r.ph = 16'h0001; r.ind = 1'b0; r.addr = '0; r.tag = "R1 reset";
        compare(r);
        insn_load = 1'b0; insn_data = '0; seq_inc = 1'b0; rst_n = 1'b1;
        mon_on = 1;

        drive(1, 16'h8ABC, 0, 0, "R2 load indirect op0");
        drive(0, 16'h7FFF, 0, 0, "R3 hold without load");
        drive(1, 16'h5123, 0, 0, "R2 load direct op5");
        for (int k = 0; k < 8; k++)
            drive(1, {1'b0, 3'(k), 12'(k * 17)}, 0, 0, "R4 op decode");
        drive(1, 16'hD055, 0, 0, "R2 load op5 before counting");
        for (int k = 0; k < 16; k++)
            drive(0, 16'h0, 1, 0, "R6 R5 step");
        drive(0, 16'h0, 1, 0, "R6 step again");
        for (int k = 0; k < 14; k++)
            drive(0, 16'h0, 1, 0, "R6 step to top");
        drive(0, 16'h0, 1, 0, "R7 wrap 15 to 0");
        drive(0, 16'h0, 1, 0, "R6 step");
        drive(0, 16'h0, 1, 0, "R6 step");
        drive(0, 16'h0, 0, 0, "R11 idle hold");
        drive(0, 16'h0, 0, 0, "R11 idle hold");
        drive(0, 16'h0, 0, 1, "R8 clear");
        drive(0, 16'h0, 1, 0, "R6 step");
        drive(0, 16'h0, 1, 0, "R6 step");
        drive(0, 16'h0, 1, 1, "R9 clear beats inc");
        // Term clear with increment held high
        drive(1, 16'h3100, 1, 0, "R2 load op3");
        drive(0, 16'h0, 1, 0, "R6 step");
        drive(0, 16'h0, 1, 0, "R6 step");
        drive(0, 16'h0, 1, 0, "R6 step to 4");
        drive(0, 16'h0, 1, 0, "R10 op3 phase4 clear with inc");
        // Term clear with no increment
        for (int k = 0; k < 4; k++)
            drive(0, 16'h0, 1, 0, "R6 step");
        drive(0, 16'h0, 0, 0, "R10 op3 phase4 clear idle");
        drive(0, 16'h0, 0, 0, "R11 hold at zero");
        // Other opcode at phase 4 must not clear
        drive(1, 16'h7004, 1, 0, "R2 load op7");
        for (int k = 0; k < 3; k++)
            drive(0, 16'h0, 1, 0, "R6 step");
        drive(0, 16'h0, 0, 0, "R10 op7 phase4 no clear");
        drive(0, 16'h0, 1, 0, "R10 op7 phase4 steps on");
        drive(0, 16'h0, 0, 0, "R3 R11 final hold");
        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule